// File: doc/BRIEF.md
# Isochronous Term Rate Scalers

This block keeps one saturating event counter for each aligned trigger term on the framework clock side, after the terms have been de-skewed. On each cycle in which the crossing-valid input is high, every asserted term adds one to its own counter. The per-term increments do not go straight to the counters. They first pass through an enable delay line whose depth equals the history depth of the crossing state recorder. A monitor snapshot of the counters therefore covers the same crossings as the term state captured alongside it.

The counters are cleared in two ways. A global timing pulse clears every channel. A register-style clear request clears either every channel or one addressed channel. A monitor capture strobe copies all counters into a snapshot bank and raises a busy flag. While the flag is high, further capture strobes are ignored, so a slow readout that spans many crossings sees one consistent set of values. The reader fetches words through a simple address/data port and then signals that the readout is complete.

Top module: `term_rate_scaler`

## Requirements
- R1: After reset, every counter and every snapshot word is zero, `snap_busy_o` is 0 and `rd_data_o` is 0.
- R2: Counter i gains exactly one for each cycle in which `xing_i` is 1 and `terms_i[i]` is 1. A term that is high while `xing_i` is 0 adds nothing.
- R3: An increment presented in cycle c reaches its counter at the clock edge that ends cycle c+HIST_DEPTH. A capture sampled in cycle t therefore includes exactly the crossings presented in cycles up to t-HIST_DEPTH-1.
- R4: A counter at all ones stays at all ones on further increments; it never wraps.
- R5: `glb_clr_i` high in a cycle clears every counter at the end of that cycle.
- R6: `reg_clr_i` high clears every counter if `reg_clr_all_i` is 1; otherwise it clears only channel `reg_clr_ch_i`, and the other counters keep counting.
- R7: If a clear reaches a counter in the same cycle as its delayed increment, the clear wins and the counter ends at zero.
- R8: `cap_i` sampled while `snap_busy_o` is 0 copies all pre-edge counter values into the snapshot bank, and `snap_busy_o` is 1 in the following cycle.
- R9: `cap_i` sampled while `snap_busy_o` is 1 has no effect; the snapshot words read out afterwards still hold the earlier capture.
- R10: `rd_done_i` sampled while `snap_busy_o` is 1 drops `snap_busy_o` in the next cycle. A `cap_i` in that same cycle is ignored, and the next `cap_i` is accepted.
- R11: `rd_en_i` sampled in cycle t loads `rd_data_o` with snapshot word `rd_addr_i` (channel index, word i = counter of `terms_i[i]`) after that edge. Without `rd_en_i`, `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Framework crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| terms_i | input | N_TERMS | Aligned term states for the current crossing |
| xing_i | input | 1 | Current cycle is a counted crossing (outside the gap) |
| glb_clr_i | input | 1 | Global timing clear pulse, all channels |
| reg_clr_i | input | 1 | Register clear request |
| reg_clr_all_i | input | 1 | Register clear applies to all channels |
| reg_clr_ch_i | input | CH_W | Channel selected by a single-channel register clear |
| cap_i | input | 1 | Monitor capture strobe |
| rd_done_i | input | 1 | Readout finished, releases the snapshot |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | CH_W | Snapshot word to read |
| rd_data_o | output | CNT_W | Registered read data |
| snap_busy_o | output | 1 | Snapshot held, captures blocked |

## Verification
Two functions meet in one cycle here: a clear and a delayed increment both reach the same counter at the same edge. The bench sets this up by asserting every term for a single crossing and then placing a single-channel or global clear exactly HIST_DEPTH cycles later. It judges the result by reading the snapshot words: the cleared channel must read zero and the others must read one. Capture and counting also coincide: capture strobes placed HIST_DEPTH and HIST_DEPTH+1 cycles after a pulse must leave that pulse out of the snapshot and include it, respectively. Release and capture are also driven together to confirm that the release takes effect and the capture is dropped.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int unsigned TERMS_DEF = 64;
  localparam int unsigned CNT_W_DEF = 32;
  localparam int unsigned HIST_DEF  = 3;

  function automatic int unsigned ch_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/scl_en_delay.sv
module scl_en_delay #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] en_o
);
  if (DEPTH == 0) begin : g_bypass
    assign en_o = en_i;
  end else begin : g_line
    logic [W-1:0] stage_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
      end else begin
        stage_q[0] <= en_i;
        for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
      end
    end
    assign en_o = stage_q[DEPTH-1];
  end
endmodule

// File: rtl/scl_sat_ctr.sv
module scl_sat_ctr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !at_max)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_clr_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  assert_sat_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max && !clr_i) |=> at_max);
  assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/scl_snap_rd.sv
module scl_snap_rd #(
  parameter int unsigned N_CH  = 64,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned CH_W  = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH*CNT_W-1:0] cnt_i,
  input  logic                  cap_i,
  input  logic                  rd_done_i,
  input  logic                  rd_en_i,
  input  logic [CH_W-1:0]       rd_addr_i,
  output logic [CNT_W-1:0]      rd_data_o,
  output logic                  busy_o
);
  localparam int unsigned BANK_W = N_CH * CNT_W;

  logic [BANK_W-1:0] snap_q;
  logic              busy_q;
  logic [CNT_W-1:0]  rd_q;
  logic [CNT_W-1:0]  rd_word;
  logic              take;

  assign take = cap_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      busy_q <= 1'b0;
    end else if (take) begin
      snap_q <= cnt_i;
      busy_q <= 1'b1;
    end else if (rd_done_i) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_CH; i++)
      if (rd_addr_i == CH_W'(i)) rd_word = snap_q[i*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_word;
  end

  assign rd_data_o = rd_q;
  assign busy_o    = busy_q;

  assert_cap_sets_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !busy_q) |=> busy_q);
  assert_snap_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(snap_q));
  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rd_done_i) |=> !busy_q);
  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_q));
endmodule

// File: rtl/term_rate_scaler.sv
module term_rate_scaler
  import scl_pkg::*;
#(
  parameter int unsigned N_TERMS    = TERMS_DEF,
  parameter int unsigned CNT_W      = CNT_W_DEF,
  parameter int unsigned HIST_DEPTH = HIST_DEF,
  localparam int unsigned CH_W      = ch_bits(N_TERMS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_TERMS-1:0] terms_i,
  input  logic               xing_i,
  input  logic               glb_clr_i,
  input  logic               reg_clr_i,
  input  logic               reg_clr_all_i,
  input  logic [CH_W-1:0]    reg_clr_ch_i,
  input  logic               cap_i,
  input  logic               rd_done_i,
  input  logic               rd_en_i,
  input  logic [CH_W-1:0]    rd_addr_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic               snap_busy_o
);
  logic [N_TERMS-1:0]       inc_now;
  logic [N_TERMS-1:0]       inc_dly;
  logic [N_TERMS-1:0]       clr_vec;
  logic [N_TERMS*CNT_W-1:0] cnt_flat;

  assign inc_now = terms_i & {N_TERMS{xing_i}};

  // enables, not counts, ride the history line
  scl_en_delay #(.W(N_TERMS), .DEPTH(HIST_DEPTH)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (inc_now),
    .en_o   (inc_dly)
  );

  for (genvar g = 0; g < N_TERMS; g++) begin : g_ch
    assign clr_vec[g] = glb_clr_i ||
                        (reg_clr_i && (reg_clr_all_i || (reg_clr_ch_i == CH_W'(g))));
    scl_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_vec[g]),
      .inc_i  (inc_dly[g]),
      .cnt_o  (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  scl_snap_rd #(.N_CH(N_TERMS), .CNT_W(CNT_W), .CH_W(CH_W)) u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt_flat),
    .cap_i     (cap_i),
    .rd_done_i (rd_done_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .busy_o    (snap_busy_o)
  );

  assert_glb_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_clr_i |=> (cnt_flat == '0));
endmodule

// File: tb/sim_term_rate_scaler.sv
module sim_term_rate_scaler;
  localparam int N = 8, CW = 6, D = 3, AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]  terms = '0;
  logic          xing = 0, gclr = 0, rclr = 0, rclr_all = 0, cap = 0, rd_en = 0, rd_done = 0;
  logic [AW-1:0] rclr_ch = '0, rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic          busy;

  term_rate_scaler #(.N_TERMS(N), .CNT_W(CW), .HIST_DEPTH(D)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .terms_i(terms), .xing_i(xing),
    .glb_clr_i(gclr), .reg_clr_i(rclr), .reg_clr_all_i(rclr_all), .reg_clr_ch_i(rclr_ch),
    .cap_i(cap), .rd_done_i(rd_done), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .snap_busy_o(busy));

  int total = 0, bad = 0;
  bit finished = 0;
  string cur_tag = "R1";

  logic [CW-1:0] m_cnt [N];
  logic [CW-1:0] m_snap [N];
  logic [N-1:0]  m_pipe [D];
  logic          m_busy = 0;
  logic [CW-1:0] m_rd = '0;
  logic          rd_pend = 0;
  logic [31:0]   lf = 32'h1234_5678;

  function automatic logic [31:0] nx(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", t, act, exp);
    end
  endtask

  task automatic cyc();
    logic [N-1:0] dl;
    logic         c;
    @(posedge clk);
    dl = m_pipe[D-1];
    rd_pend = rd_en;
    if (rd_en) m_rd = m_snap[rd_addr];
    if (!m_busy && cap) begin
      for (int i = 0; i < N; i++) m_snap[i] = m_cnt[i];
      m_busy = 1'b1;
    end else if (rd_done) m_busy = 1'b0;
    for (int i = 0; i < N; i++) begin
      c = gclr || (rclr && (rclr_all || int'(rclr_ch) == i));
      if (c) m_cnt[i] = '0;
      else if (dl[i] && m_cnt[i] != '1) m_cnt[i] = m_cnt[i] + 1'b1;
    end
    for (int k = D-1; k > 0; k--) m_pipe[k] = m_pipe[k-1];
    m_pipe[0] = xing ? terms : '0;
    @(negedge clk);
    chk({cur_tag, " R8 busy"}, busy, m_busy);
    if (rd_pend) chk({cur_tag, " R11 read word"}, rd_data, m_rd);
    gclr = 0; rclr = 0; rclr_all = 0; cap = 0; rd_en = 0; rd_done = 0;
  endtask

  task automatic read_all(input string t);
    cur_tag = t;
    for (int a = 0; a < N; a++) begin
      rd_en = 1; rd_addr = AW'(a);
      cyc();
    end
  endtask

  task automatic readout(input string t);
    cur_tag = t;
    cap = 1; cyc();
    read_all(t);
    rd_done = 1; cyc();
  endtask

  task automatic idle(input int n);
    terms = '0; xing = 0;
    for (int k = 0; k < n; k++) cyc();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_snap[i] = '0; end
    for (int k = 0; k < D; k++) m_pipe[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 busy after reset", busy, 0);
    chk("R1 read data after reset", rd_data, 0);
    readout("R1");

    // R2: random traffic, varying density, with xing gating
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 30; k++) begin
        lf = nx(lf);
        terms = lf[7:0] & ((r % 2 == 0) ? lf[15:8] : 8'hFF);
        xing = (r == 5) ? 1'b0 : (lf[16] | lf[17]);
        cyc();
      end
      readout("R2");
      rclr = 1; rclr_all = 1; cur_tag = "R6"; cyc();
    end

    // R3: capture edge relative to one pulse
    idle(D + 2);
    terms = '1; xing = 1; cyc();
    idle(D - 1);
    readout("R3 excluded");
    idle(D + 2);
    rclr = 1; rclr_all = 1; cyc();
    idle(D + 2);
    terms = '1; xing = 1; cyc();
    idle(D);
    readout("R3 included");

    // R4: saturation
    terms = '1; xing = 1;
    for (int k = 0; k < (1 << CW) + 12; k++) cyc();
    readout("R4");

    // R6: single-channel register clear on saturated counters
    for (int ch = 0; ch < N; ch++) begin
      idle(D + 1);
      rclr = 1; rclr_ch = AW'(ch); cyc();
      readout("R6");
    end

    // R7: clear lands on the same edge as a delayed increment
    for (int v = 0; v < 2; v++) begin
      gclr = 1; cyc();
      idle(D + 2);
      terms = '1; xing = 1; cyc();
      terms = '0; xing = 0;
      for (int k = 0; k < D - 1; k++) cyc();
      if (v == 0) begin rclr = 1; rclr_ch = 3'd2; end
      else gclr = 1;
      cyc();
      idle(D + 2);
      readout("R7");
    end

    // R9, R10: capture blocking and release
    terms = 8'hA5; xing = 1;
    cur_tag = "R8"; cap = 1; cyc();
    terms = 8'h3C;
    for (int k = 0; k < 6; k++) cyc();
    cur_tag = "R9"; cap = 1; cyc();
    for (int k = 0; k < 5; k++) cyc();
    read_all("R9");
    cur_tag = "R10"; rd_done = 1; cap = 1; cyc();
    cap = 1; cyc();
    read_all("R10");
    rd_done = 1; cyc();

    // R5, R6, R7 random mix
    for (int r = 0; r < 16; r++) begin
      for (int k = 0; k < 25; k++) begin
        lf = nx(lf);
        terms = lf[7:0]; xing = lf[8] | lf[9];
        gclr = (lf[15:11] == 5'd0);
        rclr = (lf[20:17] == 4'd0); rclr_all = lf[21]; rclr_ch = lf[24:22];
        cur_tag = "R5";
        cyc();
      end
      readout("R5 mix");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule